// File: doc/BRIEF.md
# Receive Address Hash Filter

This block sits on the receive byte stream of an Ethernet MAC and decides whether each frame is kept or discarded. Bytes arrive one per clock under a valid qualifier, with a marker on the first byte and another on the last byte of each frame. The first six bytes form the destination address. While they stream in, the block builds a CRC-32 over them and captures them for comparison.

At the last byte the block applies the configured rules. A unicast destination can be required to equal the station address. A multicast destination can be looked up in a 128-bit hash table, or passed without a lookup in all-multicast mode. Broadcast always passes the address stage. Frames shorter than a programmed minimum can be dropped as fragments. One clock after the last byte, the block presents a single-cycle decision strobe with an accept flag.

Configuration is written through a small word-wide write port. Written values take effect from the following clock.

Top module: `rx_addr_filter`

## Requirements
- R1: `dec_valid` is high for exactly the one cycle after a cycle with `in_valid` and `in_eof` both high, and is low at all other times, including right after reset. `dec_accept` is meaningful only while `dec_valid` is high.
- R2: When the unicast enable (control bit 0), the hash enable (control bit 1) and the fragment enable (control bit 3) are all clear, every frame is accepted, whatever its length or destination.
- R3: With control bit 0 set, a unicast frame is accepted only if its six destination bytes equal the station address. The first and second received bytes are compared with bits [7:0] and [15:8] of register 4. Received bytes three to six are compared with bits [7:0], [15:8], [23:16] and [31:24] of register 5.
- R4: A destination of all ones (broadcast) passes the address checks, whatever the enables are.
- R5: A destination whose first byte has bit 0 set, and which is not broadcast, is multicast. With control bit 1 set and control bit 2 clear, it passes only if a hash bit is set, as follows:
  - The CRC runs over the six destination bytes. It is preset to all ones and takes each byte least-significant bit first.
  - Each step shifts left, XORs 0x04C11DB7 whenever the old bit 31 differs from the data bit, and applies no final inversion.
  - CRC bits 29..23 form the index k.
  - Index k selects bit k mod 32 of hash register k/32 (registers 0 to 3).
- R6: With control bit 2 (all-multicast) set, every multicast frame passes the address stage without a hash lookup. With control bit 1 clear, multicast frames also pass it.
- R7: With control bit 3 set, a frame whose total byte count is below the 16-bit minimum in control bits [31:16] is dropped, whatever its destination. A count equal to the minimum is not a fragment.
- R8: With control bit 0 or bit 1 set, a frame that ends before its sixth byte is dropped.
- R9: A start marker begins a new frame at once. It discards any unfinished frame without a decision. Idle cycles between bytes (`in_valid` low) do not disturb the frame.
- R10: Configuration writes with `cfg_wr` high store `cfg_wdata` at `cfg_addr`: addresses 0 to 3 hold the hash words, 4 and 5 the station address, and 6 the control word. The bits of register 4 above 15 and the unused control bits are ignored. After reset, all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on in_byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_byte | input | 8 | Received byte |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Decision strobe, one cycle after the last byte |
| dec_accept | output | 1 | Frame is accepted (qualified by dec_valid) |

## Verification
Driving a multicast frame into a chosen hash bucket is the hardest case to reach from the ports, because the bucket is a CRC of the address. The bench computes the index for several multicast destinations with its own CRC routine. It then programs a table holding only that one bit and expects acceptance. Next it programs the inverted table and expects a drop. Varying the address this way places indices in several of the four hash words. Fragment handling is probed at the minimum length and one byte below it. The abort case starts a new frame in the middle of an unfinished one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int HASH_WORDS = 4;
    localparam int HASH_IDX_W = 7;
    localparam int WORD_SEL_W = $clog2(HASH_WORDS);
    localparam int BIT_SEL_W  = HASH_IDX_W - WORD_SEL_W;
    localparam int IDX_LSB    = 23;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    localparam logic [2:0] REG_HASH0 = 3'd0;
    localparam logic [2:0] REG_STA_HI = 3'd4;
    localparam logic [2:0] REG_STA_LO = 3'd5;
    localparam logic [2:0] REG_CTRL   = 3'd6;

    typedef struct packed {
        logic [HASH_WORDS-1:0][31:0] hash;
        logic [8*ADDR_BYTES-1:0]     station;
        logic [15:0]                 min_len;
        logic                        frag_en;
        logic                        all_mc;
        logic                        mc_en;
        logic                        uc_en;
    } rxf_cfg_t;

    // One byte of the address CRC: MSB-feedback shift, data taken LSB first.
    function automatic logic [31:0] crc_byte(input logic [31:0] crc_in,
                                             input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[31] ^ data[b]) c = {c[30:0], 1'b0} ^ CRC_POLY;
            else                 c = {c[30:0], 1'b0};
        end
        return c;
    endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output rxf_cfg_t    cfg
);
    rxf_cfg_t cfg_d, cfg_q;
    logic [HASH_WORDS-1:0][31:0] hash_d;

    // Per-word hash write decode.
    for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
        always_comb begin
            hash_d[w] = cfg_q.hash[w];
            if (cfg_wr && cfg_addr == REG_HASH0 + 3'(w))
                hash_d[w] = cfg_wdata;
        end
    end

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.hash = hash_d;
        if (cfg_wr) begin
            case (cfg_addr)
                REG_STA_HI: cfg_d.station[15:0]  = cfg_wdata[15:0];
                REG_STA_LO: cfg_d.station[47:16] = cfg_wdata;
                REG_CTRL: begin
                    cfg_d.uc_en   = cfg_wdata[0];
                    cfg_d.mc_en   = cfg_wdata[1];
                    cfg_d.all_mc  = cfg_wdata[2];
                    cfg_d.frag_en = cfg_wdata[3];
                    cfg_d.min_len = cfg_wdata[31:16];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/rxf_frame_track.sv
module rxf_frame_track
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [7:0]              in_byte,
    output logic [LEN_W-1:0]        len_nx,
    output logic [8*ADDR_BYTES-1:0] da_nx,
    output logic [31:0]             crc_nx
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic [LEN_W-1:0]        cnt;
        logic [8*ADDR_BYTES-1:0] da;
        logic [31:0]             crc;
    } trk_t;

    trk_t st_d, st_q;
    logic [LEN_W-1:0] idx;
    logic [31:0]      crc_base;

    always_comb begin
        st_d     = st_q;
        idx      = in_sof ? '0 : st_q.cnt;
        crc_base = in_sof ? '1 : st_q.crc;
        if (in_valid) begin
            if (in_sof) begin
                st_d.cnt = LEN_W'(1);
                st_d.da  = '0;
            end else if (st_q.cnt != LEN_MAX) begin
                st_d.cnt = st_q.cnt + LEN_W'(1);
            end
            st_d.crc = crc_base;
            if (idx < LEN_W'(ADDR_BYTES)) begin
                st_d.da[{idx[2:0], 3'b000} +: 8] = in_byte;
                st_d.crc = crc_byte(crc_base, in_byte);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, da: '0, crc: '1};
        else        st_q <= st_d;
    end

    assign len_nx = st_d.cnt;
    assign da_nx  = st_d.da;
    assign crc_nx = st_d.crc;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_byte,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        dec_valid,
    output logic        dec_accept
);
    rxf_cfg_t                cfg;
    logic [LEN_W-1:0]        len_nx;
    logic [8*ADDR_BYTES-1:0] da_nx;
    logic [31:0]             crc_nx;

    rxf_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg(cfg)
    );

    rxf_frame_track #(.LEN_W(LEN_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .len_nx(len_nx), .da_nx(da_nx), .crc_nx(crc_nx)
    );

    typedef struct packed {
        logic valid;
        logic accept;
    } dec_t;

    dec_t dec_d, dec_q;
    logic [HASH_IDX_W-1:0] hidx;
    logic hash_hit, is_bcast, is_mcast, uc_match, addr_ok, runt, short_da;
    logic [LEN_W-1:0] min_len_w;

    always_comb begin
        hidx      = crc_nx[IDX_LSB +: HASH_IDX_W];
        hash_hit  = cfg.hash[hidx[HASH_IDX_W-1 -: WORD_SEL_W]][hidx[BIT_SEL_W-1:0]];
        is_bcast  = &da_nx;
        is_mcast  = da_nx[0] && !is_bcast;
        uc_match  = (da_nx == cfg.station);
        min_len_w = LEN_W'(cfg.min_len);
        runt      = cfg.frag_en && (len_nx < min_len_w);
        short_da  = len_nx < LEN_W'(ADDR_BYTES);

        if (!cfg.uc_en && !cfg.mc_en) addr_ok = 1'b1;
        else if (short_da)            addr_ok = 1'b0;
        else if (is_bcast)            addr_ok = 1'b1;
        else if (is_mcast)            addr_ok = cfg.all_mc || !cfg.mc_en || hash_hit;
        else                          addr_ok = !cfg.uc_en || uc_match;

        dec_d.valid  = in_valid && in_eof;
        dec_d.accept = dec_d.valid && addr_ok && !runt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
endmodule

// File: rtl/rx_addr_filter_checker.sv
module rx_addr_filter_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             uc_en,
    input logic             mc_en,
    input logic             frag_en,
    input logic [15:0]      min_len,
    input logic [LEN_W-1:0] len_nx
);
    a_r1_eof_gives_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof) |=> dec_valid);

    a_r1_dec_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid && in_eof));

    a_r2_open_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(!uc_en && !mc_en && !frag_en)) |-> dec_accept);

    a_r7_runt_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(frag_en && len_nx < LEN_W'(min_len))) |-> !dec_accept);

    a_r1_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);
endmodule

bind rx_addr_filter rx_addr_filter_checker #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .uc_en(cfg.uc_en), .mc_en(cfg.mc_en), .frag_en(cfg.frag_en),
    .min_len(cfg.min_len), .len_nx(len_nx)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_byte = '0;
    logic cfg_wr = 0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic dec_valid, dec_accept;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    localparam logic [47:0] STA   = 48'h665544332210;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    function automatic logic [6:0] ref_index(input logic [47:0] da);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = r[31] ^ da[8*i+b];
                r = r << 1;
                if (fb) r = r ^ 32'h04C11DB7;
            end
        return r[29:23];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic set_hash(input logic [127:0] t);
        for (int w = 0; w < 4; w++) wr(3'(w), t[32*w +: 32]);
    endtask

    // Sends a frame and checks the decision one cycle after the last byte.
    task automatic frame(input string req, input logic [47:0] da, input int len,
                         input bit gaps, input logic exp);
        bit early = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0 && dec_valid) early = 1;
            if (gaps && i > 0) begin
                in_valid = 0;
                @(negedge clk);
                if (dec_valid) early = 1;
            end
            in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_byte = (i < 6) ? da[8*i +: 8] : 8'(i);
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        check({req, " no early strobe"}, early, 1'b0);
        check({req, " strobe"}, dec_valid, 1'b1);
        check({req, " decision"}, dec_accept, exp);
        @(negedge clk);
        check({req, " strobe one cycle"}, dec_valid, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset strobe low", dec_valid, 1'b0);
        check("R10 reset open accept", dec_accept, 1'b0);
    endtask

    task automatic t_open();
        frame("R2 short open", 48'h000000000022, 3, 0, 1'b1);
        frame("R2 foreign unicast", 48'h0A0B0C0D0E02, 60, 0, 1'b1);
        frame("R10 station unwritten R2", STA, 20, 0, 1'b1);
    endtask

    task automatic t_unicast();
        wr(3'd4, {16'hDEAD, STA[15:0]});
        wr(3'd5, STA[47:16]);
        wr(3'd6, 32'h1);
        frame("R3 match", STA, 64, 0, 1'b1);
        frame("R3 last byte differs", STA ^ 48'h800000000000, 64, 0, 1'b0);
        frame("R3 first byte differs", STA ^ 48'h000000000004, 64, 0, 1'b0);
        frame("R4 broadcast", BCAST, 64, 0, 1'b1);
        frame("R8 short address", STA, 5, 0, 1'b0);
        frame("R9 gaps", STA, 12, 1, 1'b1);
        frame("R6 multicast no hash enable", 48'h000000005E01, 64, 0, 1'b1);
    endtask

    task automatic t_hash();
        wr(3'd6, 32'h2);
        for (int k = 0; k < 6; k++) begin
            logic [47:0] da = {8'(k * 37 + 3), 32'h12345678, 8'h01};
            logic [6:0] ix = ref_index(da);
            logic [127:0] t = 128'd1 << ix;
            set_hash(t);
            frame($sformatf("R5 hit idx %0d", ix), da, 64, 0, 1'b1);
            set_hash(~t);
            frame($sformatf("R5 miss idx %0d", ix), da, 64, 0, 1'b0);
        end
        set_hash('0);
        frame("R4 broadcast empty table", BCAST, 64, 0, 1'b1);
        wr(3'd6, 32'h6);
        frame("R6 all multicast", 48'h0000000000F3, 64, 0, 1'b1);
    endtask

    task automatic t_frag();
        wr(3'd6, {16'd64, 16'h0008});
        frame("R7 below min", 48'h000000000002, 63, 0, 1'b0);
        frame("R7 at min", 48'h000000000002, 64, 0, 1'b1);
        frame("R7 broadcast runt", BCAST, 10, 0, 1'b0);
        wr(3'd6, {16'd64, 16'h0000});
        frame("R7 disabled R2", 48'h000000000002, 10, 0, 1'b1);
    endtask

    task automatic t_abort();
        wr(3'd6, 32'h1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_eof = 0; in_byte = 8'hAB;
        end
        frame("R9 restart after abort", STA, 20, 0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_reset();
        t_open();
        t_unicast();
        t_hash();
        t_frag();
        t_abort();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule